// File: doc/BRIEF.md
# Isolated Memory Region Access Filter

This block sits on the memory path and screens every transaction against eight programmable protected regions. Each region has a lower bound, an upper bound and two per-agent permission masks, one for reads and one for writes. A transaction brings an address, a direction flag and a requester ID. If any enabled region that contains the address withholds permission from that requester, the transaction is refused. A refused write never reaches memory, and a refused read returns all-ones instead of the memory word. Every refusal also raises a one-cycle reset request and is recorded in a sticky status.

Regions are set up through a small indexed register port. Each region occupies four consecutive words starting at a configurable base index. Setting the lock flag in a region's lower-bound word freezes all four of that region's words until the next reset. The permission decision is purely combinational from the transaction inputs. Only the reset request and the status are registered.

Top module: `mem_region_guard`

## Requirements
- R1: After reset every region reads lower bound 0, upper bound 0, read mask 0xFFFFFFFF and write mask 0xFFFFFFFF, and no transaction is refused.
- R2: The register at index CFG_BASE + 4*region + k is the lower bound when k=0, the upper bound when k=1, the read mask when k=2 and the write mask when k=3 (CFG_BASE defaults to 0x10). A read of any index outside this window returns 0, and a write to such an index changes nothing.
- R3: Bound words keep only bits 23:2. The lower-bound word also keeps bit 31, the lock flag. All other bits of the bound words read back as 0. Both mask words keep all 32 bits.
- R4: A region covers byte addresses from (lower<<8) up to and including (upper<<8)+0x3FF. In other words, address bits 31:10 are compared, inclusively, against bits 23:2 of the two bound words.
- R5: A region whose bound fields are both zero and whose two masks are both all-ones is disabled and refuses nothing. Any other setting, including zero bounds with a mask that is not all-ones, is enabled.
- R6: Mask bit n grants agent n access. A read is judged against the read mask and a write against the write mask. A cleared bit refuses the access.
- R7: txn_mem_we equals txn_valid and txn_write, except that it is 0 whenever the write is refused.
- R8: txn_rdata passes txn_mem_rdata through, except that it is 0xFFFFFFFF for a refused read.
- R9: Regions may overlap. A transaction is refused if any enabled region that contains it refuses it.
- R10: While bit 31 of a region's lower-bound word is set, writes to any of that region's four words are ignored, including writes that try to clear the lock.
- R11: rst_req is high in the cycle after each cycle with a refused transaction, and low otherwise.
- R12: The first refusal after reset sets viol_valid and loads viol_region with the lowest-numbered region that refused the transaction. Both then hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| txn_valid | input | 1 | Transaction present |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_addr | input | 32 | Byte address |
| txn_agent | input | 5 | Requesting agent ID |
| txn_mem_rdata | input | 32 | Data returned by memory |
| txn_rdata | output | 32 | Read data to requester |
| txn_mem_we | output | 1 | Write enable to memory |
| txn_deny | output | 1 | Transaction refused |
| rst_req | output | 1 | One-cycle reset request |
| viol_valid | output | 1 | Sticky violation flag |
| viol_region | output | 3 | Region that caused the first violation |

## Verification
A corrupted bound or mask word shows up in one of two ways, both visible in the same cycle as the transaction. The first is a readback mismatch on cfg_rdata. The second is a wrong refusal decision, seen as all-ones read data or a missing memory write enable. The bench sweeps every agent ID across addresses placed on each region boundary and one page either side of it, for both directions, against overlapping regions. A wrong disabled-encoding test or a wrong lock test therefore shows up at the first access after the affected configuration. A wrong reset-request or status register shows up one cycle after the first refusal.

// File: rtl/mrg_pkg.sv
// Package: shared constants and types for the memory region guard.
// Assumes 32-bit addresses and 1 KiB region granularity.
package mrg_pkg;
    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 10;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;   // 22 page bits
    localparam int MASK_W   = 32;
    localparam int AGENT_W  = $clog2(MASK_W);

    // Writable bits of the bound words; bit 31 of the lower bound is the lock.
    localparam logic [31:0] LO_KEEP = 32'h80FF_FFFC;
    localparam logic [31:0] HI_KEEP = 32'h00FF_FFFC;
    localparam int LOCK_BIT = 31;

    typedef enum logic [1:0] {
        SEL_LO    = 2'd0,
        SEL_HI    = 2'd1,
        SEL_RMASK = 2'd2,
        SEL_WMASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [31:0]       lo;
        logic [31:0]       hi;
        logic [MASK_W-1:0] rmask;
        logic [MASK_W-1:0] wmask;
    } region_regs_t;
endpackage

// File: rtl/mrg_region.sv
// Module: one protected region, holding its four configuration words and
// the match/refuse decision for the current transaction.
// Assumes the parent decodes the register index into wr_en and wr_sel.
module mrg_region
    import mrg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_e            wr_sel,
    input  logic [31:0]         wr_data,
    input  logic                txn_valid,
    input  logic                txn_write,
    input  logic [PAGE_W-1:0]   txn_page,
    input  logic [AGENT_W-1:0]  txn_agent,
    output region_regs_t        regs,
    output logic                deny
);
    region_regs_t regs_q;
    logic         locked;
    logic         enabled;
    logic         hit;
    logic         granted;

    assign locked = regs_q.lo[LOCK_BIT];

    // Configuration update: reserved bits dropped, frozen while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.lo    <= '0;
            regs_q.hi    <= '0;
            regs_q.rmask <= '1;
            regs_q.wmask <= '1;
        end else if (wr_en && !locked) begin
            case (wr_sel)
                SEL_LO:    regs_q.lo    <= wr_data & LO_KEEP;
                SEL_HI:    regs_q.hi    <= wr_data & HI_KEEP;
                SEL_RMASK: regs_q.rmask <= wr_data;
                default:   regs_q.wmask <= wr_data;
            endcase
        end
    end

    // Decision: enabled, address inside the inclusive page range, agent not granted.
    always_comb begin
        enabled = !((regs_q.lo[23:2] == '0) && (regs_q.hi[23:2] == '0) &&
                    (&regs_q.rmask) && (&regs_q.wmask));
        hit     = (txn_page >= regs_q.lo[23:2]) && (txn_page <= regs_q.hi[23:2]);
        granted = txn_write ? regs_q.wmask[txn_agent] : regs_q.rmask[txn_agent];
        deny    = txn_valid && enabled && hit && !granted;
    end

    assign regs = regs_q;

    // R10
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(regs_q.lo[LOCK_BIT]) |-> $stable(regs_q));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.lo & ~LO_KEEP) == '0) && ((regs_q.hi & ~HI_KEEP) == '0));

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.lo[23:2] == '0) && (regs_q.hi[23:2] == '0) &&
         (&regs_q.rmask) && (&regs_q.wmask)) |-> !deny);
endmodule

// File: rtl/mrg_viol_track.sv
// Module: turns per-region refusals into a registered one-cycle reset
// request and a sticky record of the first offending region.
// Assumes deny_vec is combinational from the current transaction.
module mrg_viol_track #(
    parameter int NUM_REGIONS = 8,
    localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_REGIONS-1:0] deny_vec,
    output logic                   rst_req,
    output logic                   viol_valid,
    output logic [RIDX_W-1:0]      viol_region
);
    logic              any_deny;
    logic [RIDX_W-1:0] first_idx;

    // Lowest-numbered refusing region wins.
    always_comb begin
        any_deny  = |deny_vec;
        first_idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (deny_vec[i]) first_idx = RIDX_W'(i);
        end
    end

    // Reset request pulse and sticky status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req     <= 1'b0;
            viol_valid  <= 1'b0;
            viol_region <= '0;
        end else begin
            rst_req <= any_deny;
            if (any_deny && !viol_valid) begin
                viol_valid  <= 1'b1;
                viol_region <= first_idx;
            end
        end
    end

    // R11
    rst_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|deny_vec) |=> rst_req);

    // R11
    rst_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|deny_vec) |=> !rst_req);

    // R12
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |=> (viol_valid && $stable(viol_region)));

    // R12
    viol_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_valid && (|deny_vec)) |=> viol_valid);
endmodule

// File: rtl/mem_region_guard.sv
// Module: top of the memory region guard. Decodes the register port,
// instantiates one mrg_region per region, combines the refusals and
// gates the memory write enable and read data.
// Assumes CFG_BASE + 4*NUM_REGIONS fits in the index width.
module mem_region_guard
    import mrg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int CFG_IDX_W   = 8,
    parameter int CFG_BASE    = 16,
    localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int NUM_WORDS  = NUM_REGIONS * 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 txn_valid,
    input  logic                 txn_write,
    input  logic [ADDR_W-1:0]    txn_addr,
    input  logic [AGENT_W-1:0]   txn_agent,
    input  logic [31:0]          txn_mem_rdata,
    output logic [31:0]          txn_rdata,
    output logic                 txn_mem_we,
    output logic                 txn_deny,
    output logic                 rst_req,
    output logic                 viol_valid,
    output logic [RIDX_W-1:0]    viol_region
);
    localparam logic [CFG_IDX_W-1:0] BASE_V  = CFG_BASE[CFG_IDX_W-1:0];
    localparam logic [CFG_IDX_W-1:0] WORDS_V = NUM_WORDS[CFG_IDX_W-1:0];

    logic [CFG_IDX_W-1:0]   rel;
    logic                   in_range;
    logic [RIDX_W-1:0]      rel_region;
    reg_sel_e               rel_sel;
    logic [PAGE_W-1:0]      txn_page;
    logic                   unused_low;
    logic [NUM_REGIONS-1:0] deny_vec;
    region_regs_t           regs_arr [NUM_REGIONS];

    // Register index decode relative to the window base.
    always_comb begin
        rel        = cfg_idx - BASE_V;
        in_range   = (cfg_idx >= BASE_V) && (rel < WORDS_V);
        rel_region = rel[RIDX_W+1:2];
        rel_sel    = reg_sel_e'(rel[1:0]);
    end

    assign txn_page   = txn_addr[ADDR_W-1:PAGE_LSB];
    assign unused_low = &{1'b0, txn_addr[PAGE_LSB-1:0]};

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
            mrg_region u_region (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (cfg_we && in_range && (rel_region == RIDX_W'(g))),
                .wr_sel    (rel_sel),
                .wr_data   (cfg_wdata),
                .txn_valid (txn_valid),
                .txn_write (txn_write),
                .txn_page  (txn_page),
                .txn_agent (txn_agent),
                .regs      (regs_arr[g]),
                .deny      (deny_vec[g])
            );
        end
    endgenerate

    // Register readback mux; zero outside the window.
    always_comb begin
        cfg_rdata = '0;
        if (in_range) begin
            case (rel_sel)
                SEL_LO:    cfg_rdata = regs_arr[rel_region].lo;
                SEL_HI:    cfg_rdata = regs_arr[rel_region].hi;
                SEL_RMASK: cfg_rdata = regs_arr[rel_region].rmask;
                default:   cfg_rdata = regs_arr[rel_region].wmask;
            endcase
        end
    end

    // Transaction gating: drop refused writes, force refused reads to all-ones.
    always_comb begin
        txn_deny   = |deny_vec;
        txn_mem_we = txn_valid && txn_write && !txn_deny;
        txn_rdata  = (txn_valid && !txn_write && txn_deny) ? '1 : txn_mem_rdata;
    end

    mrg_viol_track #(.NUM_REGIONS(NUM_REGIONS)) u_viol (
        .clk         (clk),
        .rst_n       (rst_n),
        .deny_vec    (deny_vec),
        .rst_req     (rst_req),
        .viol_valid  (viol_valid),
        .viol_region (viol_region)
    );

    // R7
    refused_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_write && (|deny_vec)) |-> !txn_mem_we);

    // R8
    refused_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_write && (|deny_vec)) |-> (txn_rdata == 32'hFFFF_FFFF));

    // R2
    out_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_idx < BASE_V) || (cfg_idx >= BASE_V + WORDS_V)) |-> (cfg_rdata == '0));
endmodule

// File: tb/test_mem_region_guard.sv
module test_mem_region_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;
    localparam int BASE = 16;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [7:0]  cfg_idx = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic        txn_valid = 0;
    logic        txn_write = 0;
    logic [31:0] txn_addr = 0;
    logic [4:0]  txn_agent = 0;
    logic [31:0] txn_mem_rdata = 0;
    logic [31:0] txn_rdata;
    logic        txn_mem_we, txn_deny, rst_req, viol_valid;
    logic [2:0]  viol_region;

    int checks = 0;
    int fails = 0;

    logic [31:0] m_lo [NREG];
    logic [31:0] m_hi [NREG];
    logic [31:0] m_rm [NREG];
    logic [31:0] m_wm [NREG];
    logic        e_vv = 0;
    logic [2:0]  e_vr = 0;

    mem_region_guard i_mem_region_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
        .txn_write(txn_write), .txn_addr(txn_addr), .txn_agent(txn_agent),
        .txn_mem_rdata(txn_mem_rdata), .txn_rdata(txn_rdata),
        .txn_mem_we(txn_mem_we), .txn_deny(txn_deny), .rst_req(rst_req),
        .viol_valid(viol_valid), .viol_region(viol_region)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Bench model of a register write, from R2, R3 and R10.
    task automatic model_write(logic [7:0] idx, logic [31:0] d);
        int rel = int'(idx) - BASE;
        if (rel >= 0 && rel < NREG*4) begin
            int r = rel / 4;
            if (!m_lo[r][31]) begin
                case (rel % 4)
                    0: m_lo[r] = d & 32'h80FF_FFFC;
                    1: m_hi[r] = d & 32'h00FF_FFFC;
                    2: m_rm[r] = d;
                    default: m_wm[r] = d;
                endcase
            end
        end
    endtask

    task automatic cfg_write(logic [7:0] idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        model_write(idx, d);
    endtask

    task automatic cfg_check(string req, logic [7:0] idx, logic [31:0] exp);
        @(negedge clk);
        cfg_idx = idx;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic check_all_regs(string req);
        for (int r = 0; r < NREG; r++) begin
            cfg_check(req, 8'(BASE + 4*r + 0), m_lo[r]);
            cfg_check(req, 8'(BASE + 4*r + 1), m_hi[r]);
            cfg_check(req, 8'(BASE + 4*r + 2), m_rm[r]);
            cfg_check(req, 8'(BASE + 4*r + 3), m_wm[r]);
        end
    endtask

    // Transaction with expected outcome from R4, R5, R6, R9; checks R7, R8, R11, R12.
    task automatic do_txn(logic wr, logic [31:0] a, logic [4:0] ag);
        logic       ed = 0;
        logic [2:0] ef = 0;
        for (int r = NREG - 1; r >= 0; r--) begin
            logic en, hit, gr;
            en  = !((m_lo[r][23:2] == 0) && (m_hi[r][23:2] == 0) &&
                    (m_rm[r] == 32'hFFFF_FFFF) && (m_wm[r] == 32'hFFFF_FFFF));
            hit = (a[31:10] >= m_lo[r][23:2]) && (a[31:10] <= m_hi[r][23:2]);
            gr  = wr ? m_wm[r][ag] : m_rm[r][ag];
            if (en && hit && !gr) begin ed = 1; ef = 3'(r); end
        end
        @(negedge clk);
        txn_valid = 1; txn_write = wr; txn_addr = a; txn_agent = ag;
        txn_mem_rdata = ~a ^ 32'h0000_5A00;
        #1;
        check("R9 deny", {31'b0, txn_deny}, {31'b0, ed});
        check("R7 mem_we", {31'b0, txn_mem_we}, {31'b0, wr && !ed});
        check("R8 rdata", txn_rdata, (!wr && ed) ? 32'hFFFF_FFFF : txn_mem_rdata);
        if (ed && !e_vv) begin e_vv = 1; e_vr = ef; end
        @(negedge clk);
        txn_valid = 0;
        check("R11 rst_req", {31'b0, rst_req}, {31'b0, ed});
        check("R12 viol_valid", {31'b0, viol_valid}, {31'b0, e_vv});
        check("R12 viol_region", {29'b0, viol_region}, {29'b0, e_vr});
    endtask

    task automatic sweep;
        logic [31:0] addrs [10] = '{32'h0, 32'h3FF, 32'h400, 32'h3FFF, 32'h4000,
                                    32'h4FFF, 32'h5000, 32'h8000, 32'h83FF, 32'h8400};
        for (int i = 0; i < 10; i++)
            for (int ag = 0; ag < 32; ag++)
                for (int w = 0; w < 2; w++)
                    do_txn(w[0], addrs[i], 5'(ag));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) begin
            m_lo[r] = 0; m_hi[r] = 0; m_rm[r] = '1; m_wm[r] = '1;
        end
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset values and no refusal
        check_all_regs("R1 reset");
        do_txn(1'b0, 32'h0, 5'd0);
        do_txn(1'b1, 32'h4000, 5'd31);

        // R2 / R3: programming with reserved bits set
        cfg_write(8'(BASE + 0), 32'h7F00_0043);   // r0 lo page 0x10
        cfg_write(8'(BASE + 1), 32'hFF00_004F);   // r0 hi page 0x13
        cfg_write(8'(BASE + 2), 32'h0000_00FF);
        cfg_write(8'(BASE + 3), 32'h0000_000F);
        cfg_write(8'(BASE + 4), 32'h0000_0048);   // r1 page 0x12..0x20
        cfg_write(8'(BASE + 5), 32'h0000_0080);
        cfg_write(8'(BASE + 6), 32'hFFFF_0000);
        cfg_write(8'(BASE + 7), 32'h0F0F_0F0F);
        cfg_write(8'(BASE + 14), 32'h0000_0000);  // r3 zero bounds, reads refused (R5)
        cfg_write(8'h30, 32'h1234_5678);          // outside window (R2)
        cfg_write(8'h0F, 32'hFFFF_FFFF);
        cfg_check("R3 lo reserved", 8'(BASE + 0), 32'h0000_0040);
        cfg_check("R3 hi reserved", 8'(BASE + 1), 32'h0000_004C);
        cfg_check("R2 above window", 8'h30, 32'h0);
        cfg_check("R2 below window", 8'h0F, 32'h0);
        check_all_regs("R2 map");

        // R4 R5 R6 R9: boundary sweep over all agents
        sweep();

        // R10: lock region 5 then try to rewrite it
        cfg_write(8'(BASE + 21), 32'h0000_0080);
        cfg_write(8'(BASE + 22), 32'h0000_0000);
        cfg_write(8'(BASE + 23), 32'h0000_0000);
        cfg_write(8'(BASE + 20), 32'h8000_0080);
        cfg_write(8'(BASE + 20), 32'h0000_0000);
        cfg_write(8'(BASE + 21), 32'h0000_0000);
        cfg_write(8'(BASE + 22), 32'hFFFF_FFFF);
        cfg_write(8'(BASE + 23), 32'hFFFF_FFFF);
        cfg_check("R10 lock lo", 8'(BASE + 20), 32'h8000_0080);
        cfg_check("R10 lock rmask", 8'(BASE + 22), 32'h0000_0000);

        // R3: all-ones into region 6 bounds
        cfg_write(8'(BASE + 25), 32'hFFFF_FFFF);
        cfg_write(8'(BASE + 24), 32'hFFFF_FFFF);
        cfg_check("R3 hi all-ones", 8'(BASE + 25), 32'h00FF_FFFC);
        cfg_check("R3 lo all-ones", 8'(BASE + 24), 32'h80FF_FFFC);
        check_all_regs("R10 readback");

        sweep();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule